// File: doc/BRIEF.md
# Quad-Rate Dual-Port Burst SRAM

This block is a synthesizable model of a static memory with a dedicated read data output and a dedicated write data input. One address bus serves both ports. The read address is taken on the rising edge of the input clock K. The write address is taken on the rising edge of the complementary input clock K#. Because the two data directions never share wires, there is no bus turnaround, and a read and a write can run in the same input-clock cycle.

Every access moves a burst of two words. A write takes its first word on the K# edge that also takes its address. It takes the second word on the next K edge, and then commits both words to the array at once. A read fetches its word pair one K cycle after the address is sampled. It launches the first word on the following rising edge of output clock C# and the second word on the next rising edge of C. A valid flag marks both words.

Two small state machines control the read side. The read stage in the K domain has the states RD_IDLE and RD_FETCH. It enters RD_FETCH on any K edge where the read select is low and returns to RD_IDLE on any K edge where the select is high. The output sequencer in the C# domain has the states OUT_QUIET and OUT_BURST. It enters OUT_BURST on any C# edge where a fetched pair is waiting and returns to OUT_QUIET otherwise. In OUT_QUIET the output repeats the last word it drove.

Top module: `qdr_sram`

## Requirements
- R1: While reset is low and right after it is released, `dout_vld` is 0 and `dout` is all zeros.
- R2: If `rd_sel_n` is 0 at a rising edge of `clk_k` at time t (period T), then word 0 of the pair at `addr` is on `dout` from t+1.5T to t+2T and word 1 from t+2T to t+2.5T, with `dout_vld` 1 in both intervals.
- R3: If `wr_sel_n` is 0 at a rising edge of `clk_kn`, that edge captures the write address from `addr` and burst word 0 from `din`. The next rising edge of `clk_k` captures burst word 1 from `din` and stores the pair, with word 0 at burst offset 0 and word 1 at burst offset 1.
- R4: A read sampled at a `clk_k` edge, followed by a write to the same address sampled at the next `clk_kn` edge, returns the pair from that write.
- R5: If `rd_sel_n` is 1 at a `clk_k` edge, no burst results from that edge. `dout_vld` stays 0 for the two matching half-cycles, and `dout` keeps the last word it drove.
- R6: If `wr_sel_n` is 1 at a `clk_kn` edge, the array is not written: a later read of the address then on `addr` returns its previous contents.
- R7: Reads sampled on consecutive `clk_k` edges produce bursts back to back, with no idle half-cycle between them and in request order.
- R8: A read and a write to different addresses in the same cycle both complete: the read returns the old pair and the write is visible to later reads.
- R9: The array holds 2^`ADDR_W` word pairs, and every address up to 2^`ADDR_W`-1 can be written and read back on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Input clock K; samples the read address and write word 1 |
| clk_kn | input | 1 | Complementary input clock K#; samples the write address and write word 0 |
| clk_c | input | 1 | Output clock C; launches read word 1 |
| clk_cn | input | 1 | Complementary output clock C#; launches read word 0 |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| rd_sel_n | input | 1 | Active-low read select, sampled on `clk_k` |
| wr_sel_n | input | 1 | Active-low write select, sampled on `clk_kn` |
| addr | input | ADDR_W | Shared address bus: read address at K, write address at K# |
| din | input | DATA_W | Write data, one word per input-clock edge |
| dout | output | DATA_W | Read data, one word per output-clock edge |
| dout_vld | output | 1 | High while `dout` carries a word of a read burst |

## Verification
The bench builds the block with `ADDR_W` = 3 and `DATA_W` = 16. This gives an eight-pair array, small enough that every address, including the top one, is written and read back within a short run. Sixteen-bit words let the two words of each pair carry distinct values, so swapped burst offsets or a stale word show up at once. The bench ties C to K and C# to K#. Under that clocking the 1.5-cycle read latency, the same-cycle forwarding case and the hold behaviour between bursts land on fixed, predictable quarter-cycle sample points.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    // Number of words moved by every access; lane index equals burst offset.
    localparam int unsigned BURST_LEN = 2;

    // Read address stage, K domain.
    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_FETCH = 1'b1
    } rd_state_e;

    // Output launch sequencer, C# domain.
    typedef enum logic {
        OUT_QUIET = 1'b0,
        OUT_BURST = 1'b1
    } out_state_e;

endpackage

// File: rtl/qdr_wr_capture.sv
module qdr_wr_capture #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18
) (
    input  logic              clk_kn,
    input  logic              rst_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_pend,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_w0
);

    // Pending flag: a write was selected at this K# edge and completes at next K.
    always_ff @(posedge clk_kn or negedge rst_n) begin
        if (!rst_n) begin
            wr_pend <= 1'b0;
        end else begin
            wr_pend <= !wr_sel_n;
        end
    end

    // Address and first burst word are held until the commit edge.
    always_ff @(posedge clk_kn) begin
        if (!wr_sel_n) begin
            wr_addr <= addr;
            wr_w0   <= din;
        end
    end

endmodule

// File: rtl/qdr_pair_array.sv
module qdr_pair_array
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18
) (
    input  logic                               clk_k,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [BURST_LEN-1:0][DATA_W-1:0]   wr_word,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [BURST_LEN-1:0][DATA_W-1:0]   rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic hit;
    assign hit = wr_en && (wr_addr == rd_addr);

    // One bank per burst offset; a commit writes every lane at once.
    for (genvar b = 0; b < BURST_LEN; b++) begin : g_lane
        logic [DATA_W-1:0] bank [DEPTH];

        always_ff @(posedge clk_k) begin
            if (wr_en) begin
                bank[wr_addr] <= wr_word[b];
            end
        end

        // A pair committed on the same K edge as the lookup is forwarded.
        assign rd_word[b] = hit ? wr_word[b] : bank[rd_addr];
    end

endmodule

// File: rtl/qdr_rd_ctrl.sv
module qdr_rd_ctrl
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18
) (
    input  logic                               clk_k,
    input  logic                               rst_n,
    input  logic                               rd_sel_n,
    input  logic [ADDR_W-1:0]                  addr,
    output logic [ADDR_W-1:0]                  look_addr,
    input  logic [BURST_LEN-1:0][DATA_W-1:0]   look_word,
    output logic [BURST_LEN-1:0][DATA_W-1:0]   rbuf,
    output logic                               rbuf_vld
);

    rd_state_e state, state_nx;

    always_comb begin
        state_nx = rd_sel_n ? RD_IDLE : RD_FETCH;
    end

    // State register.
    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk_k) begin
        if (!rd_sel_n) begin
            look_addr <= addr;
        end
    end

    // Outputs: the fetched pair and its flag.
    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) begin
            rbuf_vld <= 1'b0;
            rbuf     <= '0;
        end else begin
            unique case (state)
                RD_FETCH: begin
                    rbuf_vld <= 1'b1;
                    rbuf     <= look_word;
                end
                RD_IDLE: begin
                    rbuf_vld <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/qdr_ddr_out.sv
module qdr_ddr_out
    import qdr_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic                               clk_c,
    input  logic                               clk_cn,
    input  logic                               rst_n,
    input  logic [BURST_LEN-1:0][DATA_W-1:0]   rbuf,
    input  logic                               rbuf_vld,
    output logic [DATA_W-1:0]                  dout,
    output logic                               dout_vld,
    output logic                               beat0_vld
);

    out_state_e ostate, ostate_nx;
    logic [DATA_W-1:0] q_cn, q_c, w1_hold;
    logic              v_c, tog_c, tog_cn, last_cn;

    always_comb begin
        ostate_nx = rbuf_vld ? OUT_BURST : OUT_QUIET;
    end

    // State register, C# domain.
    always_ff @(posedge clk_cn or negedge rst_n) begin
        if (!rst_n) begin
            ostate <= OUT_QUIET;
        end else begin
            ostate <= ostate_nx;
        end
    end

    // C# launch: word 0, and word 1 staged for the next C edge.
    always_ff @(posedge clk_cn or negedge rst_n) begin
        if (!rst_n) begin
            q_cn    <= '0;
            w1_hold <= '0;
            tog_cn  <= 1'b0;
        end else begin
            tog_cn <= !tog_c;
            unique case (ostate_nx)
                OUT_BURST: begin
                    q_cn    <= rbuf[0];
                    w1_hold <= rbuf[1];
                end
                OUT_QUIET: begin
                    q_cn <= q_c;
                end
            endcase
        end
    end

    // C launch: word 1, or repeat of the last word when quiet.
    always_ff @(posedge clk_c or negedge rst_n) begin
        if (!rst_n) begin
            q_c   <= '0;
            v_c   <= 1'b0;
            tog_c <= 1'b0;
        end else begin
            tog_c <= tog_cn;
            unique case (ostate)
                OUT_BURST: begin
                    q_c <= w1_hold;
                    v_c <= 1'b1;
                end
                OUT_QUIET: begin
                    q_c <= q_cn;
                    v_c <= 1'b0;
                end
            endcase
        end
    end

    // Toggle pair tells which clock edge fired last.
    assign last_cn   = tog_c != tog_cn;
    assign beat0_vld = ostate == OUT_BURST;
    assign dout      = last_cn ? q_cn : q_c;
    assign dout_vld  = last_cn ? beat0_vld : v_c;

endmodule

// File: rtl/qdr_sram.sv
module qdr_sram
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18
) (
    input  logic              clk_k,
    input  logic              clk_kn,
    input  logic              clk_c,
    input  logic              clk_cn,
    input  logic              rst_n,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);

    logic                             wr_commit;
    logic [ADDR_W-1:0]                wr_addr;
    logic [DATA_W-1:0]                wr_w0;
    logic [BURST_LEN-1:0][DATA_W-1:0] wr_word;
    logic [ADDR_W-1:0]                look_addr;
    logic [BURST_LEN-1:0][DATA_W-1:0] look_word;
    logic [BURST_LEN-1:0][DATA_W-1:0] rbuf;
    logic                             rbuf_vld;
    logic                             beat0_vld;

    qdr_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk_kn   (clk_kn),
        .rst_n    (rst_n),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .din      (din),
        .wr_pend  (wr_commit),
        .wr_addr  (wr_addr),
        .wr_w0    (wr_w0)
    );

    // Word 1 arrives on the commit edge itself.
    assign wr_word = {din, wr_w0};

    qdr_pair_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk_k   (clk_k),
        .wr_en   (wr_commit),
        .wr_addr (wr_addr),
        .wr_word (wr_word),
        .rd_addr (look_addr),
        .rd_word (look_word)
    );

    qdr_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk_k     (clk_k),
        .rst_n     (rst_n),
        .rd_sel_n  (rd_sel_n),
        .addr      (addr),
        .look_addr (look_addr),
        .look_word (look_word),
        .rbuf      (rbuf),
        .rbuf_vld  (rbuf_vld)
    );

    qdr_ddr_out #(.DATA_W(DATA_W)) u_out (
        .clk_c     (clk_c),
        .clk_cn    (clk_cn),
        .rst_n     (rst_n),
        .rbuf      (rbuf),
        .rbuf_vld  (rbuf_vld),
        .dout      (dout),
        .dout_vld  (dout_vld),
        .beat0_vld (beat0_vld)
    );

endmodule

// File: rtl/qdr_sram_chk.sv
module qdr_sram_chk (
    input logic clk_k,
    input logic clk_kn,
    input logic rst_n,
    input logic rd_sel_n,
    input logic wr_sel_n,
    input logic beat0_vld,
    input logic wr_commit,
    input logic dout_vld
);

    // R2: a selected read launches word 0 two K edges later.
    p_burst_after_select_r2: assert property (@(posedge clk_k) disable iff (!rst_n)
        !rd_sel_n |-> ##2 beat0_vld);

    // R5: an unselected K edge launches nothing.
    p_quiet_without_select_r5: assert property (@(posedge clk_k) disable iff (!rst_n)
        rd_sel_n |-> ##2 !beat0_vld);

    // R3: a selected write commits at the following K edge.
    p_write_commits_r3: assert property (@(posedge clk_kn) disable iff (!rst_n)
        !wr_sel_n |=> wr_commit);

    // R6: an unselected write edge never commits.
    p_no_write_r6: assert property (@(posedge clk_kn) disable iff (!rst_n)
        wr_sel_n |=> !wr_commit);

    // R1: nothing valid while held in reset.
    always @(posedge clk_k) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!dout_vld && !beat0_vld && !wr_commit);
        end
    end

endmodule

bind qdr_sram qdr_sram_chk u_chk (
    .clk_k     (clk_k),
    .clk_kn    (clk_kn),
    .rst_n     (rst_n),
    .rd_sel_n  (rd_sel_n),
    .wr_sel_n  (wr_sel_n),
    .beat0_vld (beat0_vld),
    .wr_commit (wr_commit),
    .dout_vld  (dout_vld)
);

// File: tb/qdr_sram_tb.sv
`timescale 1ns/1ps
module qdr_sram_tb;

    localparam int AW = 3;
    localparam int DW = 16;
    localparam int NPAIR = 1 << AW;

    logic clk_k = 1'b0;
    logic clk_kn, clk_c, clk_cn;
    logic rst_n = 1'b0;
    logic rd_sel_n = 1'b1;
    logic wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_vld;

    always #2.5 clk_k = ~clk_k;   // 200 MHz
    assign clk_kn = ~clk_k;
    assign clk_c  = clk_k;
    assign clk_cn = ~clk_k;

    qdr_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk_k(clk_k), .clk_kn(clk_kn), .clk_c(clk_c), .clk_cn(clk_cn),
        .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model and scoreboard.
    logic [DW-1:0] m0 [NPAIR];
    logic [DW-1:0] m1 [NPAIR];
    logic [2*DW-1:0] exp_q [$];
    string           tag_q [$];
    longint          due_q [$];
    logic [DW-1:0]   pend_w1 = '0;
    logic [DW-1:0]   last_seen = '0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One input-clock cycle; called at a K rise minus a quarter period.
    task automatic cycle(input bit rd, input logic [AW-1:0] ra,
                         input bit wr, input logic [AW-1:0] wa,
                         input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                         input string tag);
        addr     = ra;
        rd_sel_n = !rd;
        din      = pend_w1;
        if (wr) begin
            m0[wa] = w0;
            m1[wa] = w1;
        end
        if (rd) begin
            exp_q.push_back({m0[ra], m1[ra]});
            tag_q.push_back(tag);
            due_q.push_back(longint'($realtime * 1000.0) + 64'd10000);
        end
        #2.5;
        addr     = wa;
        wr_sel_n = !wr;
        din      = w0;
        pend_w1  = w1;
        #2.5;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, '0, 1'b0, '0, 16'hDEAD, 16'hBEEF, "");
    endtask

    // Monitor: pops expected bursts as the design drives them.
    initial begin
        logic [2*DW-1:0] e;
        string t;
        longint due;
        wait (rst_n === 1'b1);
        forever begin
            @(posedge clk_cn);
            #1.25;
            if (dout_vld === 1'b1) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 burst without read", dout, last_seen);
                end else begin
                    e   = exp_q.pop_front();
                    t   = tag_q.pop_front();
                    due = due_q.pop_front();
                    check(longint'($realtime * 1000.0) == due, {t, " R2 word0 timing"},
                          longint'($realtime * 1000.0), due);
                    check(dout === e[DW +: DW], {t, " word0"}, dout, e[DW +: DW]);
                    @(posedge clk_k);
                    #1.25;
                    check(dout_vld === 1'b1, {t, " R2 word1 valid"}, dout_vld, 1);
                    check(dout === e[0 +: DW], {t, " word1"}, dout, e[0 +: DW]);
                    last_seen = dout;
                end
            end else begin
                check(dout === last_seen, "R5 hold while idle", dout, last_seen);
            end
        end
    end

    // Watchdog.
    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #11.25;
        rst_n = 1'b1;
        #0.5;
        check(dout_vld === 1'b0, "R1 valid after reset", dout_vld, 0);
        check(dout === '0, "R1 data after reset", dout, 0);
        @(negedge clk_k);
        #1.25;
        idle(2);

        // R3, R9: fill every pair, including the top address.
        for (int a = 0; a < NPAIR; a++)
            cycle(1'b0, '0, 1'b1, a[AW-1:0], 16'hA000 + 16'(a), 16'h5000 + 16'(a * 3), "");
        idle(1);

        // R7, R9, R3: read all pairs back to back.
        for (int a = 0; a < NPAIR; a++)
            cycle(1'b1, a[AW-1:0], 1'b0, '0, '0, '0, "R7 R9 R3 stream");
        idle(3);

        // R8: read one address while writing another, then read the written one.
        cycle(1'b1, 3'd2, 1'b1, 3'd5, 16'h1111, 16'h2222, "R8 concurrent read");
        cycle(1'b1, 3'd5, 1'b0, '0, '0, '0, "R8 written pair");
        idle(2);

        // R4: same-cycle read and write to one address forwards the new pair.
        cycle(1'b1, 3'd3, 1'b1, 3'd3, 16'h3C3C, 16'hC3C3, "R4 forward");
        cycle(1'b1, 3'd3, 1'b0, '0, '0, '0, "R4 stored");
        idle(2);

        // R6: unselected write with live address and data leaves the array alone.
        cycle(1'b0, '0, 1'b0, 3'd4, 16'hFFFF, 16'hEEEE, "");
        idle(1);
        cycle(1'b1, 3'd4, 1'b0, '0, '0, '0, "R6 unchanged");
        idle(1);

        // R5: gaps between reads; hold checked by the monitor.
        cycle(1'b1, 3'd7, 1'b0, '0, '0, '0, "R5 before gap");
        idle(3);
        cycle(1'b1, 3'd0, 1'b0, '0, '0, '0, "R5 after gap");

        // R3: read in the cycle after a write returns the new pair.
        cycle(1'b0, '0, 1'b1, 3'd6, 16'h0F0F, 16'hF0F0, "");
        cycle(1'b1, 3'd6, 1'b0, '0, '0, '0, "R3 next-cycle read");
        idle(5);

        check(exp_q.size() == 0, "R2 all bursts delivered", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule